// File: doc/BRIEF.md
# eSPI Phase CRC-8 Unit

This block computes the CRC-8 check byte that guards the two phases of an eSPI transaction. The surrounding transaction logic hands it one byte per clock, tagged with a valid bit, the phase it belongs to (command or response) and the kind of byte (opcode, header, data, status or CRC). A start-of-phase strobe restarts the running value. On the command side, the CRC byte sent by the host is compared against the running value. A mismatch raises a one-cycle error pulse, but only while checking is enabled. On the response side, the running value is the byte the transmitter appends after the last status byte.

Wait-state response opcodes are left out of the response CRC. This lets the transmitter stall with any number of wait codes without disturbing the check byte. Checking is disabled after reset. The enable arrives as a level from an external configuration register. The same enable gates the response-phase error raised when chip select is released early.

Top module: `espi_crc8_unit`

## Requirements
- R1: The CRC uses polynomial x^8+x^2+x+1 (07h) with initial value 00h, most significant bit first and no final XOR. After the nine bytes 31h..39h, crc_o reads F4h.
- R2: sop_i restarts the running value from 00h. If a valid byte arrives in the same cycle, that byte is the first byte of the new phase. With no valid byte, crc_o reads 00h in the next cycle.
- R3: In the command phase (phase_i=0), every valid byte of kind opcode (0), header (1), data (2) or status (3) is folded into the CRC.
- R4: A valid byte of kind CRC (4) is never folded, in either phase, and leaves crc_o unchanged. Kind codes 5 to 7 are also ignored.
- R5: In the command phase, a CRC-kind byte that differs from the running value makes cmd_crc_err_o high for exactly the next cycle. This happens only if crc_chk_en_i is 1 in the byte's cycle; a matching byte gives no pulse.
- R6: In the response phase (phase_i=1), valid opcode, header, data and status bytes are folded. crc_o is the byte to append, available in the cycle after the last folded byte.
- R7: In the response phase, an opcode-kind byte whose value masked by WAIT_MASK equals WAIT_CODE (default: exactly 0Fh) is not folded, even when it arrives with sop_i.
- R8: cs_abort_i raises rsp_crc_err_o in the next cycle only while crc_chk_en_i is 1; with checking disabled it has no effect.
- R9: While rst_ni is low, crc_o is 00h and both error outputs are low.
- R10: With neither byte_vld_i nor sop_i high, crc_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sop_i | input | 1 | Start-of-phase strobe |
| byte_vld_i | input | 1 | byte_i carries a byte this cycle |
| byte_i | input | 8 | Byte of the current phase |
| phase_i | input | 1 | 0 command phase, 1 response phase |
| kind_i | input | 3 | Byte kind: 0 opcode, 1 header, 2 data, 3 status, 4 CRC |
| crc_chk_en_i | input | 1 | CRC checking enabled (configuration level) |
| cs_abort_i | input | 1 | Chip select released early during a transaction |
| crc_o | output | 8 | Running CRC; the byte to append in the response phase |
| cmd_crc_err_o | output | 1 | One-cycle command CRC mismatch pulse |
| rsp_crc_err_o | output | 1 | One-cycle response-phase CRC error on early release |

## Verification
The assertions check the following on every cycle:
- crc_o holds on idle cycles, on CRC-kind bytes and on wait-state opcodes.
- A strobe with no byte returns crc_o to the initial value.
- Neither error pulse appears unless checking was enabled in the cycle before.

Only the bench scenarios can show that the CRC values themselves are right. These include the F4h check value, a response phase led by wait codes that gives the same value as a plain phase, and mismatch detection for matching versus differing CRC bytes.

// File: rtl/espi_crc_pkg.sv
package espi_crc_pkg;
  typedef enum logic [2:0] {
    KIND_OPC  = 3'd0,
    KIND_HDR  = 3'd1,
    KIND_DAT  = 3'd2,
    KIND_STS  = 3'd3,
    KIND_CRC  = 3'd4
  } byte_kind_e;

  typedef enum logic {
    PH_CMD = 1'b0,
    PH_RSP = 1'b1
  } phase_e;
endpackage

// File: rtl/espi_crc_step.sv
// One byte of CRC update, unrolled bit by bit, MSB first.
module espi_crc_step #(
  parameter int          W    = 8,
  parameter logic [W-1:0] POLY = 8'h07
) (
  input  logic [W-1:0] crc_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] stage [0:W];

  assign stage[0] = crc_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic fb;
    assign fb           = stage[i][W-1] ^ data_i[W-1-i];
    assign stage[i+1]   = {stage[i][W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc_o = stage[W];
endmodule

// File: rtl/espi_crc_classify.sv
// Decides per byte whether it is folded into the CRC or compared against it.
module espi_crc_classify #(
  parameter int           W         = 8,
  parameter logic [W-1:0] WAIT_CODE = 8'h0F,
  parameter logic [W-1:0] WAIT_MASK = 8'hFF
) (
  input  logic                      vld_i,
  input  espi_crc_pkg::phase_e      phase_i,
  input  espi_crc_pkg::byte_kind_e  kind_i,
  input  logic [W-1:0]              data_i,
  output logic                      fold_o,
  output logic                      cmp_o
);
  import espi_crc_pkg::*;

  logic is_body;
  logic is_wait;

  always_comb begin
    is_body = (kind_i == KIND_OPC) || (kind_i == KIND_HDR) ||
              (kind_i == KIND_DAT) || (kind_i == KIND_STS);
    is_wait = (phase_i == PH_RSP) && (kind_i == KIND_OPC) &&
              ((data_i & WAIT_MASK) == WAIT_CODE);
    fold_o  = vld_i && is_body && !is_wait;
    cmp_o   = vld_i && (phase_i == PH_CMD) && (kind_i == KIND_CRC);
  end
endmodule

// File: rtl/espi_crc8_unit.sv
module espi_crc8_unit #(
  parameter int           W         = 8,
  parameter logic [W-1:0] POLY      = 8'h07,
  parameter logic [W-1:0] INIT      = 8'h00,
  parameter logic [W-1:0] WAIT_CODE = 8'h0F,
  parameter logic [W-1:0] WAIT_MASK = 8'hFF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sop_i,
  input  logic         byte_vld_i,
  input  logic [W-1:0] byte_i,
  input  logic         phase_i,
  input  logic [2:0]   kind_i,
  input  logic         crc_chk_en_i,
  input  logic         cs_abort_i,
  output logic [W-1:0] crc_o,
  output logic         cmd_crc_err_o,
  output logic         rsp_crc_err_o
);
  import espi_crc_pkg::*;

  logic [W-1:0] crc_q;
  logic [W-1:0] crc_start;
  logic [W-1:0] crc_next;
  logic         fold;
  logic         cmp;
  logic         cmd_err_q;
  logic         rsp_err_q;

  // a strobe restarts the phase; a byte in the same cycle is its first byte
  assign crc_start = sop_i ? INIT : crc_q;

  espi_crc_classify #(
    .W         (W),
    .WAIT_CODE (WAIT_CODE),
    .WAIT_MASK (WAIT_MASK)
  ) u_classify (
    .vld_i   (byte_vld_i),
    .phase_i (phase_e'(phase_i)),
    .kind_i  (byte_kind_e'(kind_i)),
    .data_i  (byte_i),
    .fold_o  (fold),
    .cmp_o   (cmp)
  );

  espi_crc_step #(
    .W    (W),
    .POLY (POLY)
  ) u_step (
    .crc_i  (crc_start),
    .data_i (byte_i),
    .crc_o  (crc_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q     <= INIT;
      cmd_err_q <= 1'b0;
      rsp_err_q <= 1'b0;
    end else begin
      if (fold)       crc_q <= crc_next;
      else if (sop_i) crc_q <= INIT;
      cmd_err_q <= cmp && crc_chk_en_i && (byte_i != crc_start);
      rsp_err_q <= cs_abort_i && crc_chk_en_i;
    end
  end

  assign crc_o         = crc_q;
  assign cmd_crc_err_o = cmd_err_q;
  assign rsp_crc_err_o = rsp_err_q;
endmodule

// File: rtl/espi_crc8_chk.sv
module espi_crc8_chk #(
  parameter int           W         = 8,
  parameter logic [W-1:0] INIT      = 8'h00,
  parameter logic [W-1:0] WAIT_CODE = 8'h0F,
  parameter logic [W-1:0] WAIT_MASK = 8'hFF
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         sop_i,
  input logic         byte_vld_i,
  input logic [W-1:0] byte_i,
  input logic         phase_i,
  input logic [2:0]   kind_i,
  input logic         crc_chk_en_i,
  input logic         cs_abort_i,
  input logic [W-1:0] crc_o,
  input logic         cmd_crc_err_o,
  input logic         rsp_crc_err_o
);
  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_vld_i && !sop_i) |=> $stable(crc_o));

  a_r2_strobe_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sop_i && !byte_vld_i) |=> (crc_o == INIT));

  a_r4_crc_kind_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !sop_i && kind_i == 3'd4) |=> $stable(crc_o));

  a_r7_wait_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !sop_i && phase_i && kind_i == 3'd0 &&
     ((byte_i & WAIT_MASK) == WAIT_CODE)) |=> $stable(crc_o));

  a_r5_err_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_crc_err_o |-> $past(crc_chk_en_i && byte_vld_i && !phase_i && kind_i == 3'd4));

  a_r8_abort_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_crc_err_o |-> $past(cs_abort_i && crc_chk_en_i));
endmodule

bind espi_crc8_unit espi_crc8_chk #(
  .W (W), .INIT (INIT), .WAIT_CODE (WAIT_CODE), .WAIT_MASK (WAIT_MASK)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sop_i         (sop_i),
  .byte_vld_i    (byte_vld_i),
  .byte_i        (byte_i),
  .phase_i       (phase_i),
  .kind_i        (kind_i),
  .crc_chk_en_i  (crc_chk_en_i),
  .cs_abort_i    (cs_abort_i),
  .crc_o         (crc_o),
  .cmd_crc_err_o (cmd_crc_err_o),
  .rsp_crc_err_o (rsp_crc_err_o)
);

// File: tb/tb_espi_crc8_unit.sv
`timescale 1ns/1ps
module tb_espi_crc8_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sop = 1'b0, vld = 1'b0, ph = 1'b0, en = 1'b0, abort = 1'b0;
  logic [2:0] kind = 3'd0;
  logic [7:0] dat = 8'h00;
  logic [7:0] crc;
  logic       cmd_err, rsp_err;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  espi_crc8_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .sop_i(sop), .byte_vld_i(vld), .byte_i(dat),
    .phase_i(ph), .kind_i(kind), .crc_chk_en_i(en), .cs_abort_i(abort),
    .crc_o(crc), .cmd_crc_err_o(cmd_err), .rsp_crc_err_o(rsp_err)
  );

  typedef struct packed {
    logic       sop, vld, ph;
    logic [2:0] kind;
    logic [7:0] dat;
    logic       good, en, abort, ecmd, ersp;
  } vec_t;

  // kind 4 bytes take the model CRC (good=1) or a corrupted one (good=0)
  localparam int NV = 21;
  localparam vec_t VT [NV] = '{
    '{1'b1,1'b1,1'b0,3'd0,8'h21,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,3'd1,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,3'd1,8'h04,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,3'd4,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,3'd0,8'h02,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,3'd4,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,3'd0,8'h02,1'b0,1'b1,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,3'd2,8'hA5,1'b0,1'b1,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,3'd4,8'h00,1'b0,1'b1,1'b0,1'b1,1'b0},
    '{1'b1,1'b1,1'b0,3'd0,8'h4A,1'b0,1'b1,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,3'd4,8'h00,1'b1,1'b1,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b1,3'd0,8'h0F,1'b0,1'b1,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,3'd0,8'h0F,1'b0,1'b1,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,3'd0,8'h08,1'b0,1'b1,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,3'd1,8'h01,1'b0,1'b1,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,3'd2,8'h5C,1'b0,1'b1,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,3'd3,8'h0F,1'b0,1'b1,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,3'd4,8'hFF,1'b0,1'b1,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,1'b1,3'd0,8'h00,1'b0,1'b1,1'b1,1'b0,1'b1},
    '{1'b0,1'b0,1'b1,3'd0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,3'd0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0}
  };

  // byte-wise reference: xor the whole byte in, then shift eight times
  function automatic logic [7:0] crc_ref(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c ^ d;
    for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic v, input logic p, input logic [2:0] k,
                       input logic [7:0] d, input logic e, input logic a);
    @(negedge clk);
    sop = s; vld = v; ph = p; kind = k; dat = d; en = e; abort = a;
    @(posedge clk);
    #5;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=00 expected=01");
    finish_run();
  end

  initial begin
    logic [7:0] m_crc = 8'h00;

    // R9 reset state, inputs active but held in reset
    repeat (2) @(negedge clk);
    sop = 1'b1; vld = 1'b1; dat = 8'h55; en = 1'b1; abort = 1'b1;
    @(posedge clk); #5;
    check(crc == 8'h00, "R9 crc_o", crc, 8'h00);
    check(!cmd_err && !rsp_err, "R9 error flags", {6'd0, cmd_err, rsp_err}, 8'h00);
    @(negedge clk);
    sop = 1'b0; vld = 1'b0; en = 1'b0; abort = 1'b0;
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t       v = VT[i];
      logic [7:0] start = v.sop ? 8'h00 : m_crc;
      logic [7:0] b = (v.kind == 3'd4) ? (v.good ? start : start ^ 8'h5A) : v.dat;
      logic       fold = v.vld && (v.kind <= 3'd3) && !(v.ph && v.kind == 3'd0 && b == 8'h0F);
      m_crc = fold ? crc_ref(start, b) : start;
      drive(v.sop, v.vld, v.ph, v.kind, b, v.en, v.abort);
      check(crc == m_crc, $sformatf("R2 R3 R4 R6 R7 crc_o row %0d", i), crc, m_crc);
      check(cmd_err == v.ecmd, $sformatf("R5 cmd_crc_err_o row %0d", i), {7'd0, cmd_err}, {7'd0, v.ecmd});
      check(rsp_err == v.ersp, $sformatf("R8 rsp_crc_err_o row %0d", i), {7'd0, rsp_err}, {7'd0, v.ersp});
    end

    // R1 check value over 31h..39h in a command phase
    for (int j = 0; j < 9; j++)
      drive(j == 0, 1'b1, 1'b0, 3'd2, 8'h31 + 8'(j), 1'b1, 1'b0);
    check(crc == 8'hF4, "R1 check value", crc, 8'hF4);

    // R5 matching CRC byte: no pulse, value unchanged
    drive(1'b0, 1'b1, 1'b0, 3'd4, 8'hF4, 1'b1, 1'b0);
    check(!cmd_err, "R5 matching byte", {7'd0, cmd_err}, 8'h00);
    check(crc == 8'hF4, "R4 crc byte not folded", crc, 8'hF4);
    // R5 differing byte with checking on: one pulse
    drive(1'b0, 1'b1, 1'b0, 3'd4, 8'hF5, 1'b1, 1'b0);
    check(cmd_err, "R5 mismatch pulse", {7'd0, cmd_err}, 8'h01);
    drive(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0);
    check(!cmd_err, "R5 pulse one cycle", {7'd0, cmd_err}, 8'h00);

    // R10 idle hold
    repeat (3) drive(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0);
    check(crc == 8'hF4, "R10 idle hold", crc, 8'hF4);

    // R4 reserved kind ignored
    drive(1'b0, 1'b1, 1'b0, 3'd6, 8'h99, 1'b0, 1'b0);
    check(crc == 8'hF4, "R4 reserved kind", crc, 8'hF4);

    // R7 R6 response phase led by wait codes gives the plain value
    drive(1'b1, 1'b1, 1'b1, 3'd0, 8'h0F, 1'b0, 1'b0);
    check(crc == 8'h00, "R7 wait with strobe", crc, 8'h00);
    drive(1'b0, 1'b1, 1'b1, 3'd0, 8'h0F, 1'b0, 1'b0);
    for (int j = 0; j < 9; j++)
      drive(1'b0, 1'b1, 1'b1, 3'd2, 8'h31 + 8'(j), 1'b0, 1'b0);
    check(crc == 8'hF4, "R6 R7 response value", crc, 8'hF4);

    drive(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0);
    finish_run();
  end
endmodule